// File: doc/BRIEF.md
# Serial Flash Read Sequencer

This block sits on a small 16-bit register bus and turns byte writes from a processor into a read transaction against a serial flash. The processor writes a read command, then three address bytes, and for the fast variant one dummy byte. After that it pulls the flash contents out one byte at a time by reading a receive register. The block talks to a byte-wide flash data model through an index, a fetch strobe and a data byte that is valid in the same cycle as the index. Serial bit shifting is outside this block.

A normal read returns each flash byte directly as the receive register is read. A fast read goes through a five-deep prefetch queue. Every receive read returns the oldest queued byte, moves the rest forward, and appends a newly fetched flash byte at the tail. Writing the reset/control register abandons any transaction, refills the queue with 0xFF and stores the written word so that it can be read back.

Top module: `spi_read_seq`

## Requirements
- R1: Only bits 7:0 of a write to the transmit register (offset 0) are used; bits 15:8 have no effect.
- R2: In the ready state, byte 0x03 starts a normal read and byte 0x0B starts a fast read. Any other byte leaves the block in the ready state, still waiting for a command.
- R3: The three bytes after the command load address bits 23:16, 15:8 and 7:0, in that order.
- R4: A fast read accepts one dummy byte after the low address byte. A receive read before the dummy byte returns 0xFF and fetches nothing.
- R5: Each flash fetch raises the fetch strobe for one cycle and then increments the 24-bit address. The flash index is the low 22 bits of the address, so it wraps from 0x3FFFFF to 0x000000.
- R6: While streaming, writes to the transmit register change neither the state nor the address.
- R7: During fast-read streaming, a receive read returns the head of the five-entry queue, shifts the queue, and appends the byte fetched at the current index. The first five reads after a queue refill therefore return 0xFF.
- R8: A write to the control register (offset 2) returns the block to the ready state and fills the queue with 0xFF. A later read of offset 2 returns the written word.
- R9: During normal-read streaming, a receive read (offset 1) returns the flash byte at the current index.
- R10: A receive read while not streaming returns 0x00FF and does not advance the address.
- R11: Read data appears on bus_rdata one cycle after the read access and holds until the next read. Offsets 0 and 3 read as zero. After reset the control register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register offset: 0 transmit, 1 receive, 2 control |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| fl_rd | output | 1 | Flash fetch strobe |
| fl_addr | output | 22 | Flash byte index |
| fl_data | input | 8 | Flash byte at fl_addr, valid in the same cycle |

## Verification
Read data is registered, so a read presented before a rising edge is sampled on bus_rdata at the following falling edge. The bench drives each access on a falling edge and samples exactly one half cycle after the capturing edge. A write to the transmit or control register takes effect on the edge that ends the access, which means the next access already sees the new state. Flash data is combinational from fl_addr, so the byte returned by a normal read, or appended by a fast read, is the one at the index that held before the address incremented on that same edge. All expected bytes come from a flash content function in the bench.

// File: rtl/spi_read_seq.sv
module spi_read_seq #(
  parameter int IDX_W = 22,
  parameter int QLEN = 5,
  parameter logic [7:0] CMD_NORM = 8'h03,
  parameter logic [7:0] CMD_FAST = 8'h0B
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_en,
  input  logic             bus_wr,
  input  logic [1:0]       bus_addr,
  input  logic [15:0]      bus_wdata,
  output logic [15:0]      bus_rdata,
  output logic             fl_rd,
  output logic [IDX_W-1:0] fl_addr,
  input  logic [7:0]       fl_data
);
  localparam int AW = 24;

  typedef enum logic [3:0] {
    S_IDLE, S_NH, S_NM, S_NL, S_NRUN, S_FH, S_FM, S_FL, S_FDUM, S_FRUN
  } st_t;

  st_t st;
  logic [AW-1:0] addr_q;
  logic [15:0] ctl_q;
  logic [7:0] q [QLEN];

  wire wr_tx  = bus_en & bus_wr & (bus_addr == 2'd0);
  wire rd_rx  = bus_en & ~bus_wr & (bus_addr == 2'd1);
  wire wr_ctl = bus_en & bus_wr & (bus_addr == 2'd2);
  wire [7:0] txb = bus_wdata[7:0];
  wire streaming = (st == S_NRUN) || (st == S_FRUN);

  assign fl_rd = rd_rx & streaming;
  assign fl_addr = addr_q[IDX_W-1:0];

  logic [7:0] rx_byte;
  always_comb begin
    if (st == S_NRUN)      rx_byte = fl_data;
    else if (st == S_FRUN) rx_byte = q[0];
    else                   rx_byte = 8'hFF;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      addr_q <= '0;
      ctl_q <= '0;
      for (int i = 0; i < QLEN; i++) q[i] <= 8'hFF;
    end else if (wr_ctl) begin
      st <= S_IDLE;
      ctl_q <= bus_wdata;
      for (int i = 0; i < QLEN; i++) q[i] <= 8'hFF;
    end else begin
      if (wr_tx) begin
        case (st)
          S_IDLE: begin
            if (txb == CMD_NORM)      st <= S_NH;
            else if (txb == CMD_FAST) st <= S_FH;
          end
          S_NH, S_FH: begin
            addr_q[23:16] <= txb;
            st <= (st == S_NH) ? S_NM : S_FM;
          end
          S_NM, S_FM: begin
            addr_q[15:8] <= txb;
            st <= (st == S_NM) ? S_NL : S_FL;
          end
          S_NL: begin addr_q[7:0] <= txb; st <= S_NRUN; end
          S_FL: begin addr_q[7:0] <= txb; st <= S_FDUM; end
          S_FDUM: st <= S_FRUN;
          default: ;
        endcase
      end
      if (fl_rd) begin
        addr_q <= addr_q + 1'b1;
        if (st == S_FRUN) begin
          for (int i = 0; i < QLEN-1; i++) q[i] <= q[i+1];
          q[QLEN-1] <= fl_data;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= '0;
    else if (bus_en && !bus_wr) begin
      case (bus_addr)
        2'd1:    bus_rdata <= {8'h00, rx_byte};
        2'd2:    bus_rdata <= ctl_q;
        default: bus_rdata <= '0;
      endcase
    end
  end

  assert_tx_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_tx && streaming) |=> ($stable(st) && $stable(addr_q)));

  assert_idle_rx_ff_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rx && !streaming) |=> (bus_rdata == 16'h00FF && $stable(addr_q)));

  assert_fetch_incr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fl_rd |=> (addr_q == $past(addr_q) + 24'd1));

  assert_ctl_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctl |=> (st == S_IDLE && q[0] == 8'hFF && q[QLEN-1] == 8'hFF));

  assert_normal_direct_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rx && st == S_NRUN) |=> (bus_rdata == {8'h00, $past(fl_data)}));
endmodule

// File: tb/spi_read_seq_test.sv
`timescale 1ns/1ps
module spi_read_seq_test;
  logic clk = 0, rst_n = 0;
  logic bus_en = 0, bus_wr = 0;
  logic [1:0] bus_addr = 0;
  logic [15:0] bus_wdata = 0;
  logic [15:0] bus_rdata;
  logic fl_rd;
  logic [21:0] fl_addr;
  logic [7:0] fl_data;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  function automatic logic [7:0] fbyte(input logic [21:0] a);
    return a[7:0] ^ a[15:8] ^ {2'b00, a[21:16]};
  endfunction
  assign fl_data = fbyte(fl_addr);

  spi_read_seq uut (.clk, .rst_n, .bus_en, .bus_wr, .bus_addr, .bus_wdata,
                    .bus_rdata, .fl_rd, .fl_addr, .fl_data);

  task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); bus_en = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_en = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk); bus_en = 1; bus_wr = 0; bus_addr = a;
    @(negedge clk); bus_en = 0; d = bus_rdata;
  endtask

  task automatic start(input logic [7:0] cmd, input logic [23:0] a);
    wr(0, {8'h00, cmd}); wr(0, {8'h00, a[23:16]}); wr(0, {8'h00, a[15:8]}); wr(0, {8'h00, a[7:0]});
  endtask

  task automatic t_reset();
    logic [15:0] d;
    rd(2, d); check("R11 ctl after reset", d, 16'h0000);
    rd(1, d); check("R10 rx idle", d, 16'h00FF);
    rd(0, d); check("R11 tx offset reads zero", d, 16'h0000);
    rd(3, d); check("R11 offset 3 reads zero", d, 16'h0000);
  endtask

  task automatic t_normal();
    logic [15:0] d;
    wr(2, 16'h1234);
    rd(2, d); check("R8 ctl readback", d, 16'h1234);
    @(negedge clk); check("R11 rdata held", bus_rdata, 16'h1234);
    wr(0, 16'hAA03); wr(0, 16'h5512); wr(0, 16'h0034); wr(0, 16'hFF56);
    for (int i = 0; i < 3; i++) begin
      rd(1, d); check("R1 R3 R9 normal byte", d, {8'h00, fbyte(22'h123456 + i)});
    end
    check("R5 index advanced", {10'h0, fl_addr[21:16]}, 16'h0012);
  endtask

  task automatic t_ignore();
    logic [15:0] d;
    wr(0, 16'h000B); wr(0, 16'h0000); wr(0, 16'h0003);
    rd(1, d); check("R6 tx ignored while streaming", d, {8'h00, fbyte(22'h123459)});
  endtask

  task automatic t_wrap();
    logic [15:0] d;
    wr(2, 16'h0000);
    start(8'h03, 24'hFFFFFE);
    rd(1, d); check("R5 byte at 3FFFFE", d, {8'h00, fbyte(22'h3FFFFE)});
    rd(1, d); check("R5 byte at 3FFFFF", d, {8'h00, fbyte(22'h3FFFFF)});
    rd(1, d); check("R5 wrapped to 0", d, {8'h00, fbyte(22'h000000)});
  endtask

  task automatic t_badcmd();
    logic [15:0] d;
    wr(2, 16'h0001);
    wr(0, 16'h0005);
    rd(1, d); check("R2 unknown command stays ready", d, 16'h00FF);
    start(8'h03, 24'h000010);
    rd(1, d); check("R2 normal command after unknown", d, {8'h00, fbyte(22'h000010)});
    rd(1, d); check("R10 no advance while idle earlier", d, {8'h00, fbyte(22'h000011)});
  endtask

  task automatic t_fast();
    logic [15:0] d;
    wr(2, 16'h00F0);
    start(8'h0B, 24'h010203);
    rd(1, d); check("R4 read before dummy", d, 16'h00FF);
    wr(0, 16'h0077);
    for (int i = 0; i < 5; i++) begin
      rd(1, d); check("R7 queued 0xFF", d, 16'h00FF);
    end
    rd(1, d); check("R4 R7 first flash byte", d, {8'h00, fbyte(22'h010203)});
    rd(1, d); check("R7 second flash byte", d, {8'h00, fbyte(22'h010204)});
  endtask

  task automatic t_ctl_abort();
    logic [15:0] d;
    wr(2, 16'hBEEF);
    rd(1, d); check("R8 ready after ctl write", d, 16'h00FF);
    rd(2, d); check("R8 ctl readback", d, 16'hBEEF);
    start(8'h0B, 24'hC00020);
    wr(0, 16'h0000);
    rd(1, d); check("R8 queue refilled with FF", d, 16'h00FF);
    check("R5 index masked to 22 bits", {10'h0, fl_addr[21:16]}, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_normal();
    t_ignore();
    t_wrap();
    t_badcmd();
    t_fast();
    t_ctl_abort();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule